// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the master of a single-wire serialized interrupt bus. The bus is clocked by the system bus clock, and the line is shared open-drain style. The host opens each interrupt cycle with a Start Frame. It then steps through a programmable number of three-clock IRQ/data frames. In the first clock of frame n it samples the line and stores the level as interrupt slot n on a parallel output vector; a low level means the interrupt is asserted. After the last frame it closes the cycle with a Stop Frame. The low width of the Stop Frame tells every agent how the next cycle will begin.

A two-clock Stop Frame selects quiet mode. In quiet mode the host stays idle until some slave pulls the line low, at least two clocks after the Stop Frame was released. The host then drives the line for the rest of the Start Frame and runs the cycle. A three-clock Stop Frame selects continuous mode. In continuous mode the host opens the next cycle by itself, exactly two clocks after the release. The line is released during reset. The interrupt outputs hold a default pattern until the initial cycle has sampled real values. If software clears the quiet-mode control while the host is idle in quiet mode, the host opens a cycle at once and so returns the bus to continuous mode.

Top module: `sirq_host`

## Requirements
- R1: While rst_n is low, sio_oe is 0 and irq_out equals the DEF_IRQ parameter (default all zeros). The pattern stays on irq_out until the first cycle samples new values, and a reset in the middle of a cycle restores it.
- R2: On the first clock edge after reset is released, the host begins a Start Frame. It drives the line low (sio_oe=1) for 4 clocks and then releases it for 1 turnaround clock. Frame 0 begins right after the turnaround clock.
- R3: Each frame is 3 clocks long. The line level in the first clock of frame n is captured into irq_out[n], with low giving 1 and high giving 0. irq_out bits change only in the clock after such a sample.
- R4: The frame count of a cycle is cfg_frames clamped to the range MIN_FRAMES (17) to NSLOT (32), latched when the Start Frame begins. irq_out bits at or above that count keep their previous values.
- R5: Right after the last frame, the host drives a Stop Frame. It is 2 clocks low if cfg_quiet was 1 when the Stop Frame began, and 3 clocks low if cfg_quiet was 0.
- R6: After a 3-clock Stop Frame, the host leaves the line released for exactly 2 clocks and then begins a 4-clock Start Frame on its own.
- R7: After a 2-clock Stop Frame, the host never starts a cycle by itself while cfg_quiet stays 1. When it samples the line low in idle, it drives the line for 3 further clocks (4 low clocks in total), then a turnaround clock and the frames.
- R8: While idle in quiet mode with the line high, cfg_quiet=0 makes the host begin a 4-clock Start Frame in the next clock. That cycle ends with a 3-clock Stop Frame.
- R9: A low level on the line during the 2 clocks after a 2-clock Stop Frame is released does not start a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all driving and sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sio_in | input | 1 | Sampled level of the shared interrupt line |
| sio_oe | output | 1 | Output enable for the line driver (1 = host pulls the line) |
| sio_out | output | 1 | Value driven while enabled (always low, open-drain style) |
| cfg_frames | input | CFGW | Requested frames per cycle, clamped to MIN_FRAMES..NSLOT |
| cfg_quiet | input | 1 | 1 requests quiet mode for the next cycle, 0 forces continuous mode |
| irq_out | output | NSLOT | Interrupt slot vector, 1 = asserted |

## Verification
The bench locks onto the bus timing from the ports. It counts each run of clocks with sio_oe high and each gap with it low, sampling at falling edges, and it drives the slave level for frame n at the falling edge that opens that frame. The sample then lands on the next rising edge. irq_out[n] is due one clock after the first clock of frame n, so the bench compares the whole vector on the first released clock after the Stop Frame, when every sample of the cycle is complete. A Start Frame is due on the first edge after reset release, two clocks after a continuous release, one clock after a slave pulls the line low in quiet idle, and one clock after cfg_quiet drops in quiet idle. The bench checks each of these by the exact count of released clocks before sio_oe rises.

// File: rtl/sirq_pkg.sv
// Shared types and timing constants for the serial interrupt host.
// Assumes: one bus clock, everything on its rising edge.
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,   // one clock after reset, line released
        ST_START,  // host pulls line low for the Start Frame
        ST_TURN,   // one released clock before frame 0
        ST_FRAME,  // IRQ/data frames, 3 clocks each
        ST_STOP,   // host pulls line low for the Stop Frame
        ST_GAP,    // two released clocks after the Stop Frame
        ST_QIDLE   // quiet mode: wait for a slave start
    } sirq_st_t;

    localparam int START_LAST  = 3;  // last count value of the 4-clock start
    localparam int GAP_LAST    = 1;  // last count value of the 2-clock gap
    localparam int PH_SAMPLE   = 0;  // frame phase in which the line is sampled
    localparam int PH_LAST     = 2;  // last phase of a 3-clock frame

endpackage

// File: rtl/sirq_cfg.sv
// Configuration latch: clamps the requested frame count and holds it for a
// cycle, and holds the stop-width mode from the start of each Stop Frame.
// Assumes: NSLOT < 2**CFGW and MIN_FRAMES <= NSLOT.
module sirq_cfg #(
    parameter int NSLOT      = 32,
    parameter int MIN_FRAMES = 17,
    parameter int CFGW       = 8,
    localparam int IW        = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFGW-1:0] cfg_frames,
    input  logic            cfg_quiet,
    input  logic            load_cyc,
    input  logic            load_mode,
    output logic [IW-1:0]   last_idx,
    output logic            quiet_q
);

    logic [CFGW-1:0] n_eff;

    // Clamp the requested frame count to the legal range.
    always_comb begin
        if (cfg_frames < CFGW'(MIN_FRAMES))
            n_eff = CFGW'(MIN_FRAMES);
        else if (cfg_frames > CFGW'(NSLOT))
            n_eff = CFGW'(NSLOT);
        else
            n_eff = cfg_frames;
    end

    // Latch the last frame index when a Start Frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_idx <= IW'(MIN_FRAMES - 1);
        else if (load_cyc)
            last_idx <= IW'(n_eff - CFGW'(1));
    end

    // Latch the mode when a Stop Frame begins; reset leaves slaves continuous.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_q <= 1'b0;
        else if (load_mode)
            quiet_q <= cfg_quiet;
    end

endmodule

// File: rtl/sirq_seq.sv
// Cycle sequencer: walks start, turnaround, frames, stop and gap, and in
// quiet mode waits for a slave-driven start or a forced return to
// continuous mode.
// Assumes: last_idx and quiet_q come from registers (no combinational loop).
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          cfg_quiet,
    input  logic          quiet_q,
    input  logic [IW-1:0] last_idx,
    output sirq_st_t      st,
    output logic          drive_low,
    output logic          samp_en,
    output logic [IW-1:0] samp_idx,
    output logic          load_cyc,
    output logic          load_mode
);

    sirq_st_t      st_n;
    logic [1:0]    cnt, cnt_n;
    logic [1:0]    ph, ph_n;
    logic [IW-1:0] fidx, fidx_n;
    logic [1:0]    stop_last;

    assign stop_last = quiet_q ? 2'd1 : 2'd2;

    // Next-state, counters and load strobes.
    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        ph_n      = ph;
        fidx_n    = fidx;
        load_cyc  = 1'b0;
        load_mode = 1'b0;
        unique case (st)
            ST_BOOT: begin
                st_n     = ST_START;
                cnt_n    = 2'd0;
                load_cyc = 1'b1;
            end
            ST_START: begin
                if (cnt == 2'(START_LAST)) st_n = ST_TURN;
                else                       cnt_n = cnt + 2'd1;
            end
            ST_TURN: begin
                st_n   = ST_FRAME;
                ph_n   = 2'd0;
                fidx_n = '0;
            end
            ST_FRAME: begin
                if (ph == 2'(PH_LAST)) begin
                    ph_n = 2'd0;
                    if (fidx == last_idx) begin
                        st_n      = ST_STOP;
                        cnt_n     = 2'd0;
                        load_mode = 1'b1;
                    end else begin
                        fidx_n = fidx + IW'(1);
                    end
                end else begin
                    ph_n = ph + 2'd1;
                end
            end
            ST_STOP: begin
                if (cnt == stop_last) begin
                    st_n  = ST_GAP;
                    cnt_n = 2'd0;
                end else begin
                    cnt_n = cnt + 2'd1;
                end
            end
            ST_GAP: begin
                if (cnt == 2'(GAP_LAST)) begin
                    if (quiet_q) begin
                        st_n = ST_QIDLE;
                    end else begin
                        st_n     = ST_START;
                        cnt_n    = 2'd0;
                        load_cyc = 1'b1;
                    end
                end else begin
                    cnt_n = cnt + 2'd1;
                end
            end
            ST_QIDLE: begin
                if (!line_in) begin
                    st_n     = ST_START;   // slave already gave one low clock
                    cnt_n    = 2'd1;
                    load_cyc = 1'b1;
                end else if (!cfg_quiet) begin
                    st_n     = ST_START;
                    cnt_n    = 2'd0;
                    load_cyc = 1'b1;
                end
            end
            default: st_n = ST_BOOT;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_BOOT;
            cnt  <= 2'd0;
            ph   <= 2'd0;
            fidx <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            ph   <= ph_n;
            fidx <= fidx_n;
        end
    end

    assign drive_low = (st == ST_START) || (st == ST_STOP);
    assign samp_en   = (st == ST_FRAME) && (ph == 2'(PH_SAMPLE));
    assign samp_idx  = fidx;

endmodule

// File: rtl/sirq_cap.sv
// Slot capture bank: one flop per interrupt slot, loaded with the inverted
// line level when its frame's sample phase is active.
// Assumes: samp_idx < NSLOT whenever samp_en is high.
module sirq_cap #(
    parameter int              NSLOT   = 32,
    parameter logic [NSLOT-1:0] DEF_IRQ = '0,
    localparam int             IW      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             samp_en,
    input  logic [IW-1:0]    samp_idx,
    output logic [NSLOT-1:0] irq
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        // Capture slot i in its sample phase; low line means asserted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                irq[i] <= DEF_IRQ[i];
            else if (samp_en && (samp_idx == IW'(i)))
                irq[i] <= ~line_in;
        end
    end

endmodule

// File: rtl/sirq_host.sv
// Serial interrupt bus host: top level tying together the sequencer, the
// configuration latch and the slot capture bank.
// Assumes: the line is open-drain; sio_out is the value driven when sio_oe=1.
module sirq_host
    import sirq_pkg::*;
#(
    parameter int               NSLOT      = 32,
    parameter int               MIN_FRAMES = 17,
    parameter int               CFGW       = 8,
    parameter logic [NSLOT-1:0] DEF_IRQ    = '0,
    localparam int              IW         = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sio_in,
    output logic             sio_oe,
    output logic             sio_out,
    input  logic [CFGW-1:0]  cfg_frames,
    input  logic             cfg_quiet,
    output logic [NSLOT-1:0] irq_out
);

    sirq_st_t      st;
    logic          drive_low, samp_en, load_cyc, load_mode, quiet_q;
    logic [IW-1:0] samp_idx, last_idx;

    sirq_seq #(.NSLOT(NSLOT)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_in(sio_in), .cfg_quiet(cfg_quiet),
        .quiet_q(quiet_q), .last_idx(last_idx), .st(st),
        .drive_low(drive_low), .samp_en(samp_en), .samp_idx(samp_idx),
        .load_cyc(load_cyc), .load_mode(load_mode)
    );

    sirq_cfg #(.NSLOT(NSLOT), .MIN_FRAMES(MIN_FRAMES), .CFGW(CFGW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_frames(cfg_frames),
        .cfg_quiet(cfg_quiet), .load_cyc(load_cyc), .load_mode(load_mode),
        .last_idx(last_idx), .quiet_q(quiet_q)
    );

    sirq_cap #(.NSLOT(NSLOT), .DEF_IRQ(DEF_IRQ)) u_cap (
        .clk(clk), .rst_n(rst_n), .line_in(sio_in), .samp_en(samp_en),
        .samp_idx(samp_idx), .irq(irq_out)
    );

    assign sio_oe  = drive_low;
    assign sio_out = 1'b0;

endmodule

// File: rtl/sirq_host_chk.sv
// Protocol checker for sirq_host, attached by bind.
// Assumes: synchronous active-low reset; counters here watch windows.
module sirq_host_chk
    import sirq_pkg::*;
#(
    parameter int  NSLOT      = 32,
    parameter int  MIN_FRAMES = 17,
    localparam int IW         = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sio_in,
    input logic             sio_oe,
    input logic             cfg_quiet,
    input logic [NSLOT-1:0] irq_out,
    input sirq_st_t         st,
    input logic             quiet_q,
    input logic             samp_en,
    input logic [IW-1:0]    samp_idx
);

    logic [1:0] run_q, gap_q;

    // Count consecutive Stop Frame clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= 2'd0;
        else if (st == ST_STOP)    run_q <= run_q + 2'd1;
        else                       run_q <= 2'd0;
    end

    // Count released clocks before the line is driven again (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= 2'd3;
        else if (sio_oe)        gap_q <= 2'd0;
        else if (gap_q != 2'd3) gap_q <= gap_q + 2'd1;
    end

    a_r1_released_in_reset: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> !sio_oe);

    a_r3_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(irq_out));

    a_r4_min_frames: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_STOP) |-> ($past(samp_idx) >= IW'(MIN_FRAMES - 1)));

    a_r5_stop_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_STOP && st != ST_STOP) |-> (run_q == (quiet_q ? 2'd2 : 2'd3)));

    a_r6_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_oe) |-> (gap_q >= 2'd2));

    a_r7_takeover: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_QIDLE && !sio_in) |=> sio_oe);

    a_r8_force_cont: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_QIDLE && sio_in && !cfg_quiet) |=> sio_oe);

endmodule

bind sirq_host sirq_host_chk #(.NSLOT(NSLOT), .MIN_FRAMES(MIN_FRAMES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sio_in(sio_in), .sio_oe(sio_oe),
    .cfg_quiet(cfg_quiet), .irq_out(irq_out), .st(st), .quiet_q(quiet_q),
    .samp_en(samp_en), .samp_idx(samp_idx)
);

// File: tb/sim_sirq_host.sv
// Self-checking bench for sirq_host: a table of cycles, then directed
// quiet-mode, forced-continuous and mid-cycle reset tests.
module sim_sirq_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slv = 1'b1;
    logic        cfg_quiet = 1'b0;
    logic [7:0]  cfg_frames = 8'd17;
    logic        sio_oe, sio_out;
    logic [31:0] irq_out;
    logic        sio_in;
    int          checks = 0, errs = 0;
    logic [31:0] exp_irq = '0;
    bit          done = 0;

    always #10 clk = ~clk;
    assign sio_in = sio_oe ? sio_out : slv;

    sirq_host u0 (
        .clk(clk), .rst_n(rst_n), .sio_in(sio_in), .sio_oe(sio_oe),
        .sio_out(sio_out), .cfg_frames(cfg_frames), .cfg_quiet(cfg_quiet),
        .irq_out(irq_out)
    );

    // pattern, cfg_frames, cfg_quiet
    localparam logic [40:0] VEC [4] = '{
        {32'hA5A5_0F0F, 8'd17,  1'b0},
        {32'h5A3C_96E1, 8'd32,  1'b0},
        {32'hFFFF_FFFF, 8'd5,   1'b0},
        {32'h8000_0001, 8'd200, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    function automatic int eff(input int f);
        return (f < 17) ? 17 : ((f > 32) ? 32 : f);
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // Count falling edges with sio_oe high; ends on the first released clock.
    task automatic count_low(output int n);
        n = 0;
        while (sio_oe === 1'b1 && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Count released clocks until the host drives again.
    task automatic count_gap(output int n);
        n = 0;
        while (sio_oe !== 1'b1 && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    // From the turnaround clock: drive frames, check stop and captured slots.
    task automatic finish_cycle(input logic [31:0] pat, input int f, input bit q);
        int n, len;
        logic [31:0] m;
        n = eff(f);
        m = mask_of(n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slv = ~pat[i];
            @(negedge clk); slv = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        count_low(len);
        chk(len == (q ? 2 : 3), "R5", "stop width", len, q ? 2 : 3);
        exp_irq = (exp_irq & ~m) | (pat & m);
        chk((irq_out & m) == (exp_irq & m), "R3", "sampled slots", irq_out & m, exp_irq & m);
        if (n < 32)
            chk((irq_out & ~m) == (exp_irq & ~m), "R4", "slots beyond count",
                irq_out & ~m, exp_irq & ~m);
    endtask

    initial begin
        int s, g;
        bit ok;
        cfg_frames = VEC[0][8:1];
        cfg_quiet  = VEC[0][0];
        repeat (3) @(negedge clk);
        chk(sio_oe == 1'b0, "R1", "oe in reset", 32'(sio_oe), 0);
        chk(irq_out == 32'h0, "R1", "defaults in reset", irq_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of cycles, all continuous except the last stop.
        for (int k = 0; k < 4; k++) begin
            if (k == 0) begin
                chk(irq_out == 32'h0, "R1", "defaults before first cycle", irq_out, 0);
            end else begin
                cfg_frames = VEC[k][8:1];
                cfg_quiet  = VEC[k][0];
                count_gap(g);
                chk(g == 2, "R6", "continuous gap", g, 2);
            end
            count_low(s);
            chk(s == 4, "R2", "start width", s, 4);
            finish_cycle(VEC[k][40:9], int'(VEC[k][8:1]), VEC[k][0]);
        end

        // Quiet mode: early low ignored, no self start, slave takeover.
        cfg_frames = 8'd20;
        cfg_quiet  = 1'b1;
        @(negedge clk); slv = 1'b0;        // second gap clock: too early
        @(negedge clk); slv = 1'b1;
        chk(sio_oe == 1'b0, "R9", "early low ignored", 32'(sio_oe), 0);
        ok = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sio_oe !== 1'b0) ok = 0;
        end
        chk(ok, "R7", "no host start in quiet idle", 32'(ok), 1);
        slv = 1'b0;
        @(negedge clk); slv = 1'b1;
        count_low(s);
        chk(s == 3, "R7", "host takeover clocks", s, 3);
        finish_cycle(32'h1234_5678, 20, 1'b1);

        // Forced return to continuous mode from quiet idle.
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(sio_oe == 1'b0, "R8", "idle before force", 32'(sio_oe), 0);
        cfg_quiet  = 1'b0;
        cfg_frames = 8'd17;
        @(negedge clk);
        chk(sio_oe == 1'b1, "R8", "start one clock after force", 32'(sio_oe), 1);
        count_low(s);
        chk(s == 4, "R8", "forced start width", s, 4);
        finish_cycle(32'hFFFF_0000, 17, 1'b0);
        count_gap(g);
        chk(g == 2, "R6", "gap after forced cycle", g, 2);
        count_low(s);
        chk(s == 4, "R2", "start width after gap", s, 4);

        // Reset in the middle of a cycle, slaves asserting everything.
        slv = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        slv   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sio_oe == 1'b0, "R1", "oe in mid-cycle reset", 32'(sio_oe), 0);
        chk(irq_out == 32'h0, "R1", "defaults after mid-cycle reset", irq_out, 0);
        exp_irq = '0;
        rst_n = 1'b1;
        @(negedge clk);
        count_low(s);
        chk(s == 4, "R2", "start after reset", s, 4);
        finish_cycle(32'h0000_00FF, 17, 1'b0);

        done = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule